// File: doc/BRIEF.md
# Pseudo-Channel Command Admission Checker

This block sits in a memory controller in front of one stacked-DRAM channel. That channel either works as one wide channel (legacy mode) or splits into two pseudo channels that share a single command bus. Each cycle the scheduler offers at most one candidate command: a type, a bank number and a sub-channel select bit. In the same cycle the block answers with a grant, a timing stall or a protocol error.

A granted command updates the per-bank open/closed state and the timing counters of the pseudo channel it targets. The two pseudo channels keep fully separate timing state, so traffic to one never holds back the other. The shared commands (power-down entry and exit, self-refresh entry and exit, mode-register set) wait until both pseudo channels are quiet. For reads and writes the block also drives a data-lane enable mask that shows which half of the 128-lane data bus the access will use.

Command type codes on `cmdType`: 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 power-down entry, 6 power-down exit, 7 self-refresh entry, 8 self-refresh exit, 9 mode-register set. Codes 10 to 15 are not recognised.

Top module: `pchan_admit`

## Requirements
- R1: After reset every bank of both pseudo channels is closed and every timing counter is zero, so a first activate is granted at once and a read to any bank is a protocol error.
- R2: With `pseudoMode`=0, `cmdSub` is ignored: all commands use pseudo channel 0 state and timing, and a granted read or write drives all `LANES` bits of `laneMask` high.
- R3: With `pseudoMode`=1, `cmdSub`=0 targets pseudo channel 0 and `cmdSub`=1 targets pseudo channel 1. A granted read or write drives `laneMask` bits [LANES/2-1:0] for channel 0 or bits [LANES-1:LANES/2] for channel 1, with the other half low.
- R4: A read or write to a pseudo channel stalls until T_RCD cycles after the most recent activate granted in that channel.
- R5: An activate stalls until T_RRD cycles after the previous activate granted in the same pseudo channel.
- R6: A precharge stalls until T_RAS cycles after the last activate and T_RTP cycles after the last read granted in the same pseudo channel.
- R7: An activate stalls until T_RP cycles after the last precharge granted in the same pseudo channel.
- R8: A command to one pseudo channel is never stalled by the counters of the other.
- R9: The shared commands (codes 5 to 9) are granted only when every counter of both pseudo channels is zero. In particular, self-refresh entry waits for T_RP after precharges in both channels.
- R10: `cfgErr` is high whenever `pseudoMode`=1 and `burstLen4`=0. While it is high no command is granted, and every valid recognised command stalls. Legacy mode with `burstLen4`=0 is legal.
- R11: Without a configuration error, an activate to an open bank or a read/write to a closed bank raises `protoErr` for that cycle. Such a command is neither granted nor stalled and changes no state. A precharge to a closed bank is legal and is granted.
- R12: `grant`, `stall` and `protoErr` answer the presented command in the same cycle and are never both high. With `cmdValid`=0 or an unrecognised code all three are low, and `laneMask` is zero in every cycle without a granted read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pseudoMode | input | 1 | 1 = two pseudo channels, 0 = legacy single channel |
| burstLen4 | input | 1 | 1 = burst length 4, 0 = burst length 2 |
| cmdValid | input | 1 | A candidate command is presented |
| cmdType | input | 4 | Command type code |
| cmdBank | input | BANK_W | Bank number within the pseudo channel |
| cmdSub | input | 1 | Pseudo-channel select |
| grant | output | 1 | Command admitted this cycle |
| stall | output | 1 | Command must wait for timing or configuration |
| protoErr | output | 1 | Command violates bank open/closed state |
| cfgErr | output | 1 | Pseudo mode selected with burst length 2 |
| laneMask | output | LANES | Data lanes used by a granted read or write |

## Verification
Every answer is combinational. `grant`, `stall`, `protoErr`, `cfgErr` and `laneMask` belong to the command presented in that same cycle, so the bench samples them late in the low clock phase, before the edge that commits the command. A counter loaded by a grant in cycle k releases its constraint in cycle k+T. The bench therefore builds each stall-then-grant pair from that count: the stall is presented in cycle k+T-1 and the grant in cycle k+T, and every expected item is queued for exactly the cycle in which its command is on the bus.

// File: rtl/pchan_admit_pkg.sv
package pchan_admit_pkg;

  typedef enum logic [3:0] {
    CMD_IDLE = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_PDE  = 4'd5,
    CMD_PDX  = 4'd6,
    CMD_SRE  = 4'd7,
    CMD_SRX  = 4'd8,
    CMD_MRS  = 4'd9
  } cmd_e;

  // strobes from control to datapath, valid only for granted commands
  typedef struct packed {
    logic actGo;
    logic rdGo;
    logic preGo;
    logic pcSel;
  } strobe_t;

endpackage

// File: rtl/pchan_admit_cnt.sv
// Down counter: loads on a strobe, then counts to zero and holds there.
module pchan_admit_cnt #(
  parameter int WIDTH    = 4,
  parameter int LOAD_VAL = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic zero
);
  logic [WIDTH-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN)             count <= '0;
    else if (load)         count <= WIDTH'(LOAD_VAL);
    else if (count != '0)  count <= count - 1'b1;
  end

  assign zero = (count == '0);
endmodule

// File: rtl/pchan_admit_dp.sv
// Datapath: per-pseudo-channel timing counters and bank open bitmaps.
module pchan_admit_dp
  import pchan_admit_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = 4,
  parameter int T_RCD     = 4,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RTP     = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [BANK_W-1:0]         bank,
  output logic [1:0]                rrdZero,
  output logic [1:0]                rcdZero,
  output logic [1:0]                rasZero,
  output logic [1:0]                rpZero,
  output logic [1:0]                rtpZero,
  output logic [1:0][NUM_BANKS-1:0] bankOpen
);
  localparam int CNT_W = $clog2(T_RCD + T_RRD + T_RAS + T_RP + T_RTP + 1);

  for (genvar pc = 0; pc < 2; pc++) begin : g_pc
    logic hit;
    assign hit = (stb.pcSel == pc[0]);

    pchan_admit_cnt #(.WIDTH(CNT_W), .LOAD_VAL(T_RRD - 1)) u_rrd (
      .clk(clk), .rstN(rstN), .load(stb.actGo && hit), .zero(rrdZero[pc]));
    pchan_admit_cnt #(.WIDTH(CNT_W), .LOAD_VAL(T_RCD - 1)) u_rcd (
      .clk(clk), .rstN(rstN), .load(stb.actGo && hit), .zero(rcdZero[pc]));
    pchan_admit_cnt #(.WIDTH(CNT_W), .LOAD_VAL(T_RAS - 1)) u_ras (
      .clk(clk), .rstN(rstN), .load(stb.actGo && hit), .zero(rasZero[pc]));
    pchan_admit_cnt #(.WIDTH(CNT_W), .LOAD_VAL(T_RP - 1)) u_rp (
      .clk(clk), .rstN(rstN), .load(stb.preGo && hit), .zero(rpZero[pc]));
    pchan_admit_cnt #(.WIDTH(CNT_W), .LOAD_VAL(T_RTP - 1)) u_rtp (
      .clk(clk), .rstN(rstN), .load(stb.rdGo && hit), .zero(rtpZero[pc]));

    always_ff @(posedge clk) begin
      if (!rstN)                  bankOpen[pc]       <= '0;
      else if (stb.actGo && hit)  bankOpen[pc][bank] <= 1'b1;
      else if (stb.preGo && hit)  bankOpen[pc][bank] <= 1'b0;
    end
  end
endmodule

// File: rtl/pchan_admit_ctrl.sv
// Control: decodes the candidate command and decides grant/stall/error.
module pchan_admit_ctrl
  import pchan_admit_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = 4,
  parameter int LANES     = 128
) (
  input  logic                      pseudoMode,
  input  logic                      burstLen4,
  input  logic                      cmdValid,
  input  logic [3:0]                cmdType,
  input  logic [BANK_W-1:0]         cmdBank,
  input  logic                      cmdSub,
  input  logic [1:0]                rrdZero,
  input  logic [1:0]                rcdZero,
  input  logic [1:0]                rasZero,
  input  logic [1:0]                rpZero,
  input  logic [1:0]                rtpZero,
  input  logic [1:0][NUM_BANKS-1:0] bankOpen,
  output logic                      grant,
  output logic                      stall,
  output logic                      protoErr,
  output logic                      cfgErr,
  output logic [LANES-1:0]          laneMask,
  output strobe_t                   stb
);
  localparam int HALF = LANES / 2;

  logic tgt, isAct, isRdWr, isPre, isShared, known;
  logic isOpen, allClear, timingOk, protoBad;

  always_comb begin
    tgt      = pseudoMode & cmdSub;
    isAct    = (cmdType == CMD_ACT);
    isRdWr   = (cmdType == CMD_RD) || (cmdType == CMD_WR);
    isPre    = (cmdType == CMD_PRE);
    isShared = (cmdType >= CMD_PDE) && (cmdType <= CMD_MRS);
    known    = isAct || isRdWr || isPre || isShared;
    isOpen   = bankOpen[tgt][cmdBank];
    allClear = &{rrdZero, rcdZero, rasZero, rpZero, rtpZero};

    timingOk = 1'b0;
    if (isAct)        timingOk = rrdZero[tgt] && rpZero[tgt];
    else if (isRdWr)  timingOk = rcdZero[tgt];
    else if (isPre)   timingOk = rasZero[tgt] && rtpZero[tgt];
    else if (isShared) timingOk = allClear;

    protoBad = (isAct && isOpen) || (isRdWr && !isOpen);

    cfgErr   = pseudoMode && !burstLen4;
    protoErr = cmdValid && known && !cfgErr && protoBad;
    grant    = cmdValid && known && !cfgErr && !protoBad && timingOk;
    stall    = cmdValid && known && !grant && !protoErr;

    stb.actGo = grant && isAct;
    stb.rdGo  = grant && (cmdType == CMD_RD);
    stb.preGo = grant && isPre;
    stb.pcSel = tgt;

    laneMask = '0;
    if (grant && isRdWr) begin
      if (!pseudoMode) laneMask = '1;
      else if (tgt)    laneMask = {{HALF{1'b1}}, {HALF{1'b0}}};
      else             laneMask = {{HALF{1'b0}}, {HALF{1'b1}}};
    end
  end
endmodule

// File: rtl/pchan_admit.sv
// Thin top: control plus datapath.
module pchan_admit
  import pchan_admit_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int LANES     = 128,
  parameter int T_RCD     = 4,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RTP     = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pseudoMode,
  input  logic              burstLen4,
  input  logic              cmdValid,
  input  logic [3:0]        cmdType,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              cmdSub,
  output logic              grant,
  output logic              stall,
  output logic              protoErr,
  output logic              cfgErr,
  output logic [LANES-1:0]  laneMask
);
  strobe_t                   stb;
  logic [1:0]                rrdZero, rcdZero, rasZero, rpZero, rtpZero;
  logic [1:0][NUM_BANKS-1:0] bankOpen;

  pchan_admit_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .LANES(LANES)) u_ctrl (
    .pseudoMode(pseudoMode), .burstLen4(burstLen4), .cmdValid(cmdValid),
    .cmdType(cmdType), .cmdBank(cmdBank), .cmdSub(cmdSub),
    .rrdZero(rrdZero), .rcdZero(rcdZero), .rasZero(rasZero),
    .rpZero(rpZero), .rtpZero(rtpZero), .bankOpen(bankOpen),
    .grant(grant), .stall(stall), .protoErr(protoErr), .cfgErr(cfgErr),
    .laneMask(laneMask), .stb(stb));

  pchan_admit_dp #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .T_RCD(T_RCD),
                   .T_RRD(T_RRD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RTP(T_RTP)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bank(cmdBank),
    .rrdZero(rrdZero), .rcdZero(rcdZero), .rasZero(rasZero),
    .rpZero(rpZero), .rtpZero(rtpZero), .bankOpen(bankOpen));
endmodule

// File: rtl/pchan_admit_chk.sv
// Port-level checker bound to the top.
module pchan_admit_chk #(
  parameter int LANES = 128,
  parameter int T_RCD = 4,
  parameter int T_RP  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             pseudoMode,
  input logic             burstLen4,
  input logic             cmdValid,
  input logic [3:0]       cmdType,
  input logic             cmdSub,
  input logic             grant,
  input logic             stall,
  input logic             protoErr,
  input logic             cfgErr,
  input logic [LANES-1:0] laneMask
);
  logic tgt, rdWr;
  assign tgt  = pseudoMode & cmdSub;
  assign rdWr = (cmdType == 4'd2) || (cmdType == 4'd3);

  assert_grant_stall_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && stall));

  assert_cfg_blocks_grant_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !grant);

  assert_proto_neither_R11: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> (!grant && !stall));

  assert_lane_half_R3: assert property (@(posedge clk) disable iff (!rstN)
    (grant && pseudoMode && rdWr) |-> ($countones(laneMask) == LANES / 2));

  assert_lane_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !pseudoMode && rdWr) |-> (&laneMask));

  if (T_RCD > 1) begin : g_rcd
    assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
      (grant && cmdType == 4'd1) |=> !(grant && rdWr && tgt == $past(tgt)));
  end

  if (T_RP > 1) begin : g_rp
    assert_sre_after_pre_R9: assert property (@(posedge clk) disable iff (!rstN)
      (grant && cmdType == 4'd4) |=> !(grant && cmdType == 4'd7));
  end
endmodule

bind pchan_admit pchan_admit_chk #(.LANES(LANES), .T_RCD(T_RCD), .T_RP(T_RP)) u_chk (
  .clk(clk), .rstN(rstN), .pseudoMode(pseudoMode), .burstLen4(burstLen4),
  .cmdValid(cmdValid), .cmdType(cmdType), .cmdSub(cmdSub), .grant(grant),
  .stall(stall), .protoErr(protoErr), .cfgErr(cfgErr), .laneMask(laneMask));

// File: tb/pchan_admit_bench.sv
module pchan_admit_bench;
  localparam int LANES = 128;
  localparam int HALF  = LANES / 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pseudoMode = 1'b1;
  logic             burstLen4 = 1'b1;
  logic             cmdValid = 1'b0;
  logic [3:0]       cmdType = 4'd0;
  logic [3:0]       cmdBank = 4'd0;
  logic             cmdSub = 1'b0;
  logic             grant, stall, protoErr, cfgErr;
  logic [LANES-1:0] laneMask;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pchan_admit u_pchan_admit (
    .clk(clk), .rstN(rstN), .pseudoMode(pseudoMode), .burstLen4(burstLen4),
    .cmdValid(cmdValid), .cmdType(cmdType), .cmdBank(cmdBank), .cmdSub(cmdSub),
    .grant(grant), .stall(stall), .protoErr(protoErr), .cfgErr(cfgErr),
    .laneMask(laneMask));

  typedef struct {
    logic       g, s, p, c;
    logic [1:0] mk;   // 0 none, 1 lower half, 2 upper half, 3 all
    string      tag;
  } exp_t;

  exp_t expQ[$];

  // command codes
  localparam logic [3:0] IDL = 4'd0, ACT = 4'd1, RD = 4'd2, WR = 4'd3, PRE = 4'd4,
                         PDE = 4'd5, SRE = 4'd7, SRX = 4'd8, MRS = 4'd9, BAD = 4'd12;

  task automatic issue(input logic pm, input logic bl4, input logic v,
                       input logic [3:0] t, input logic [3:0] b, input logic sub,
                       input logic eg, input logic es, input logic ep, input logic ec,
                       input logic [1:0] mk, input string tag);
    exp_t e;
    @(negedge clk);
    #1;
    pseudoMode = pm; burstLen4 = bl4; cmdValid = v;
    cmdType = t; cmdBank = b; cmdSub = sub;
    e.g = eg; e.s = es; e.p = ep; e.c = ec; e.mk = mk; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: samples late in the low phase, before the committing edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (expQ.size() > 0) begin
        exp_t e;
        logic [LANES-1:0] em;
        e = expQ.pop_front();
        case (e.mk)
          2'd1:    em = {{HALF{1'b0}}, {HALF{1'b1}}};
          2'd2:    em = {{HALF{1'b1}}, {HALF{1'b0}}};
          2'd3:    em = '1;
          default: em = '0;
        endcase
        testCount++;
        if (grant !== e.g || stall !== e.s || protoErr !== e.p || cfgErr !== e.c ||
            laneMask !== em) begin
          failCount++;
          $display("FAIL %s: got g=%0b s=%0b p=%0b c=%0b mask=%h, expected g=%0b s=%0b p=%0b c=%0b mask=%h",
                   e.tag, grant, stall, protoErr, cfgErr, laneMask,
                   e.g, e.s, e.p, e.c, em);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    //     pm bl v  type bank sub  g  s  p  c  mk
    issue(1, 1, 0, IDL, 0, 0,  0, 0, 0, 0, 0, "R1 reset idle");
    issue(1, 1, 1, RD,  2, 0,  0, 0, 1, 0, 0, "R1 read closed after reset");      // c0
    issue(1, 1, 1, ACT, 2, 0,  1, 0, 0, 0, 0, "R1 first activate");                // c1
    issue(1, 1, 1, ACT, 5, 0,  0, 1, 0, 0, 0, "R5 act-act stall");                 // c2
    issue(1, 1, 1, ACT, 5, 0,  1, 0, 0, 0, 0, "R5 act-act release");               // c3
    issue(1, 1, 1, ACT, 3, 1,  1, 0, 0, 0, 0, "R8 pc1 act not blocked");           // c4
    issue(1, 1, 1, RD,  2, 0,  0, 1, 0, 0, 0, "R4 pc0 read stall");                // c5
    issue(1, 1, 1, RD,  3, 1,  0, 1, 0, 0, 0, "R4 pc1 read stall");                // c6
    issue(1, 1, 1, RD,  2, 0,  1, 0, 0, 0, 1, "R3 R4 pc0 read lower lanes");       // c7
    issue(1, 1, 1, RD,  3, 1,  1, 0, 0, 0, 2, "R3 pc1 read upper lanes");          // c8
    issue(1, 1, 1, MRS, 0, 0,  0, 1, 0, 0, 0, "R9 mode set waits pc1");            // c9
    issue(1, 1, 1, WR,  5, 0,  1, 0, 0, 0, 1, "R3 pc0 write lower lanes");         // c10
    issue(1, 1, 1, PRE, 2, 0,  1, 0, 0, 0, 0, "R6 precharge after ras/rtp");       // c11
    issue(1, 1, 1, ACT, 2, 0,  0, 1, 0, 0, 0, "R7 act waits rp");                  // c12
    issue(1, 1, 1, SRE, 0, 0,  0, 1, 0, 0, 0, "R9 self-refresh waits rp");         // c13
    issue(1, 1, 1, ACT, 2, 0,  1, 0, 0, 0, 0, "R7 act after rp");                  // c14
    issue(1, 1, 1, ACT, 3, 1,  0, 0, 1, 0, 0, "R11 act to open bank");             // c15
    issue(1, 1, 1, RD,  9, 1,  0, 0, 1, 0, 0, "R11 read to closed bank");          // c16
    issue(1, 1, 1, PRE, 2, 0,  0, 1, 0, 0, 0, "R6 precharge waits ras");           // c17
    issue(1, 1, 0, ACT, 2, 0,  0, 0, 0, 0, 0, "R12 invalid ignored");              // c18
    issue(1, 1, 1, IDL, 0, 0,  0, 0, 0, 0, 0, "R12 idle code");                    // c19
    issue(1, 1, 1, SRE, 0, 0,  1, 0, 0, 0, 0, "R9 self-refresh granted");          // c20
    issue(1, 1, 1, SRX, 0, 0,  1, 0, 0, 0, 0, "R9 self-refresh exit");             // c21
    issue(1, 1, 1, BAD, 0, 0,  0, 0, 0, 0, 0, "R12 unknown code");                 // c22
    issue(1, 1, 1, PRE, 7, 1,  1, 0, 0, 0, 0, "R11 precharge closed bank legal");  // c23
    issue(1, 1, 1, RD,  2, 0,  1, 0, 0, 0, 1, "R8 pc0 read while pc1 in rp");      // c24
    issue(1, 1, 1, PRE, 2, 0,  0, 1, 0, 0, 0, "R6 precharge waits rtp");           // c25
    issue(1, 1, 1, PRE, 2, 0,  1, 0, 0, 0, 0, "R6 precharge after rtp");           // c26
    issue(0, 1, 1, ACT, 2, 1,  0, 1, 0, 0, 0, "R2 legacy uses pc0 rp");            // c27
    issue(0, 1, 0, IDL, 0, 0,  0, 0, 0, 0, 0, "R12 idle");                         // c28
    issue(0, 1, 1, ACT, 2, 1,  1, 0, 0, 0, 0, "R2 legacy act");                    // c29
    issue(0, 1, 1, WR,  5, 1,  0, 1, 0, 0, 0, "R2 R4 legacy write waits rcd");     // c30
    issue(0, 1, 0, IDL, 0, 0,  0, 0, 0, 0, 0, "R12 idle");                         // c31
    issue(0, 1, 0, IDL, 0, 0,  0, 0, 0, 0, 0, "R12 idle");                         // c32
    issue(0, 1, 1, WR,  5, 1,  1, 0, 0, 0, 3, "R2 legacy write all lanes");        // c33
    issue(1, 0, 1, ACT, 9, 0,  0, 1, 0, 1, 0, "R10 config error stalls act");      // c34
    issue(1, 0, 1, RD,  9, 0,  0, 1, 0, 1, 0, "R10 config error stalls read");     // c35
    issue(1, 0, 0, IDL, 0, 0,  0, 0, 0, 1, 0, "R10 config error flag idle");       // c36
    issue(0, 0, 1, ACT, 9, 0,  1, 0, 0, 0, 0, "R10 legacy with bl2 legal");        // c37
    issue(0, 0, 1, PDE, 0, 0,  0, 1, 0, 0, 0, "R9 power-down waits counters");     // c38
    wait (expQ.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule